// File: doc/BRIEF.md
# Multi-Source Reset Controller

This block merges every reset request on a small chip into one stretched system reset and a CPU reset that follows it. The requests are power-on, an external pin, the digital watchdog, the sleep counter, wake-up on input change, and the command to enter SLEEP. Each source other than power-on and sleep entry needs two things to act: its software enable must be set, and the current operating mode must allow it. Any request that gets through restarts a down-counter. The system reset stays asserted until that counter has run for the set number of clock cycles after the last request.

The block separates a cold reset from a warm reset. Power-on is the only cold source. It clears the persistent register bits and the sleep-enable latch, and it sets a POR status flag. Software clears that flag by writing 1 to it. A warm reset from any other source leaves the persistent bits, the latch and the flag unchanged. The persistent bits and the sleep-enable latch live inside this block, so both kinds of reset can be seen at its ports.

The debounce filters, oscillators, watchdog counter and sleep counter sit outside the block. They reach it as one-cycle request pulses, all synchronous to `clk`. The power-on input is a synchronous, active-high reset.

Top module: `rst_hub`

## Requirements
- R1: While `pwr_on_rst` is high, each clock edge sets `sys_rst`, `cpu_rst`, `cold_rst` and `por_flag` to 1, and clears `persist_q` and `sleep_en` to 0.
- R2: A request sampled at a clock edge makes `sys_rst` high right after that edge. `sys_rst` then stays high for exactly STRETCH cycles (default 16) after the last edge on which a request or `pwr_on_rst` was sampled. With no request, `sys_rst` stays low.
- R3: `cpu_rst` equals `sys_rst` in every cycle.
- R4: `cold_rst` rises only through `pwr_on_rst`. It falls on the same edge as `sys_rst`. A reset started only by warm sources keeps `cold_rst` low.
- R5: A warm reset leaves `persist_q`, `sleep_en` and `por_flag` unchanged.
- R6: `pin_evt` makes a request only when `pin_en` is 1 and `op_mode` is ACTIVE (0) or STAND-BY (1).
- R7: `wdog_evt` makes a request only when `wdog_en` is 1 and `op_mode` is ACTIVE (0) or STAND-BY (1).
- R8: `wake_evt` makes a request only when `wake_en` is 1 and `op_mode` is SLEEP (2). Mode value 3 is reserved and allows none of the gated sources.
- R9: `slpcnt_evt` makes a request only when `slpcnt_en` is 1 and `op_mode` is ACTIVE (0).
- R10: `sleep_entry_evt` makes a request in every mode and needs no enable.
- R11: A request that arrives while the stretch is running reloads the counter, so the reset ends STRETCH cycles after that new request.
- R12: A high `por_flag_clr` with `pwr_on_rst` low clears `por_flag` on the next edge. When both are high, the flag is set.
- R13: While `sys_rst` is high, writes to `persist_q` (`persist_we`) and the sleep-latch controls `sleep_en_set` and `sleep_en_clr` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| pwr_on_rst | input | 1 | Power-on (cold) reset, active high, synchronous |
| op_mode | input | 2 | Operating mode: 0 ACTIVE, 1 STAND-BY, 2 SLEEP, 3 reserved |
| pin_evt | input | 1 | Debounced external pin reset pulse |
| pin_en | input | 1 | Software enable for the pin source |
| wdog_evt | input | 1 | Watchdog timeout pulse |
| wdog_en | input | 1 | Software enable for the watchdog source |
| slpcnt_evt | input | 1 | Sleep-counter timeout pulse |
| slpcnt_en | input | 1 | Software enable for the sleep-counter source |
| wake_evt | input | 1 | Debounced wake-on-change pulse |
| wake_en | input | 1 | Software enable for the wake source |
| sleep_entry_evt | input | 1 | Pulse issued when SLEEP is being entered |
| por_flag_clr | input | 1 | Write-1 clear of the POR status flag |
| persist_we | input | 1 | Write strobe for the persistent bits |
| persist_wdata | input | PW | Data for the persistent bits |
| sleep_en_set | input | 1 | Sets the sleep-enable latch |
| sleep_en_clr | input | 1 | Clears the sleep-enable latch |
| sys_rst | output | 1 | Stretched system reset |
| cpu_rst | output | 1 | CPU reset, same timing as sys_rst |
| cold_rst | output | 1 | High during a reset that began with power-on |
| por_flag | output | 1 | POR status flag |
| persist_q | output | PW | Persistent register bits |
| sleep_en | output | 1 | Sleep-enable latch |

## Verification
The assertions check several relations in every cycle. A qualified request is always followed by `sys_rst`, and the reset never ends on an edge that saw a request. `sys_rst` cannot rise from nothing, and `cold_rst` can only appear through power-on. The persistent bits and the sleep latch hold still while the reset is active, and a flag clear takes effect.

Only the bench's scenarios can show the other behaviours. These are the exact stretch length, the restart on a late request, and the full enable-by-mode table. The bench drives randomized sources, enables and modes, and checks that the stored bits survive each warm reset with their old values.

// File: rtl/rst_hub_pkg.sv
package rst_hub_pkg;

    typedef enum logic [1:0] {
        MODE_ACTIVE  = 2'd0,
        MODE_STANDBY = 2'd1,
        MODE_SLEEP   = 2'd2,
        MODE_RSVD    = 2'd3
    } op_mode_e;

    typedef enum logic [2:0] {
        SRC_PIN    = 3'd0,
        SRC_WDOG   = 3'd1,
        SRC_SLPCNT = 3'd2,
        SRC_WAKE   = 3'd3,
        SRC_SLEEP  = 3'd4
    } src_id_e;

    localparam int NSRC = 5;

    typedef struct packed {
        logic sleep_entry;
        logic wake;
        logic slpcnt;
        logic wdog;
        logic pin;
    } src_vec_t;

    // Mode table: which warm sources may act in which operating mode.
    function automatic logic mode_allows(input src_id_e id, input op_mode_e m);
        logic ok;
        case (id)
            SRC_PIN,
            SRC_WDOG:   ok = (m == MODE_ACTIVE) || (m == MODE_STANDBY);
            SRC_SLPCNT: ok = (m == MODE_ACTIVE);
            SRC_WAKE:   ok = (m == MODE_SLEEP);
            SRC_SLEEP:  ok = 1'b1;
            default:    ok = 1'b0;
        endcase
        return ok;
    endfunction

    // Sources that need no software enable.
    function automatic logic always_enabled(input src_id_e id);
        return id == SRC_SLEEP;
    endfunction

endpackage

// File: rtl/rst_gate.sv
module rst_gate
    import rst_hub_pkg::*;
(
    input  src_vec_t raw,
    input  src_vec_t en,
    input  op_mode_e mode,
    output src_vec_t qual,
    output logic     req_any
);
    logic [NSRC-1:0] raw_v;
    logic [NSRC-1:0] en_v;
    logic [NSRC-1:0] qual_v;

    assign raw_v = raw;
    assign en_v  = en;

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        localparam src_id_e ID = src_id_e'(i);
        logic en_ok;
        if (always_enabled(ID)) begin : g_free
            assign en_ok = 1'b1;
        end else begin : g_sw
            assign en_ok = en_v[i];
        end
        assign qual_v[i] = raw_v[i] & en_ok & mode_allows(ID, mode);
    end

    assign qual    = qual_v;
    assign req_any = |qual_v;
endmodule

// File: rtl/rst_stretch.sv
module rst_stretch #(
    parameter int STRETCH = 16
) (
    input  logic clk,
    input  logic por,
    input  logic req,
    output logic sys_rst,
    output logic cpu_rst,
    output logic cold_rst
);
    localparam int CW = $clog2(STRETCH + 1);
    localparam logic [CW-1:0] LOAD = CW'(STRETCH);
    localparam logic [CW-1:0] ONE  = CW'(1);

    logic [CW-1:0] cnt_q;
    logic          cold_q;

    always_ff @(posedge clk) begin
        if (por) begin
            cnt_q  <= LOAD;
            cold_q <= 1'b1;
        end else if (req) begin
            cnt_q  <= LOAD;
        end else if (cnt_q != '0) begin
            cnt_q  <= cnt_q - ONE;
            if (cnt_q == ONE) cold_q <= 1'b0;
        end
    end

    assign sys_rst  = (cnt_q != '0);
    assign cpu_rst  = sys_rst;
    assign cold_rst = cold_q & sys_rst;
endmodule

// File: rtl/rst_persist.sv
module rst_persist #(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          por,
    input  logic          sys_rst,
    input  logic          flag_clr,
    input  logic          we,
    input  logic [PW-1:0] wdata,
    input  logic          slp_set,
    input  logic          slp_clr,
    output logic          por_flag,
    output logic [PW-1:0] bits_q,
    output logic          slp_en
);
    always_ff @(posedge clk) begin
        if (por) begin
            bits_q <= '0;
            slp_en <= 1'b0;
        end else if (!sys_rst) begin
            if (we) bits_q <= wdata;
            if (slp_clr)      slp_en <= 1'b0;
            else if (slp_set) slp_en <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (por)           por_flag <= 1'b1;
        else if (flag_clr) por_flag <= 1'b0;
    end
endmodule

// File: rtl/rst_hub.sv
module rst_hub
    import rst_hub_pkg::*;
#(
    parameter int STRETCH = 16,
    parameter int PW      = 8
) (
    input  logic          clk,
    input  logic          pwr_on_rst,
    input  logic [1:0]    op_mode,
    input  logic          pin_evt,
    input  logic          pin_en,
    input  logic          wdog_evt,
    input  logic          wdog_en,
    input  logic          slpcnt_evt,
    input  logic          slpcnt_en,
    input  logic          wake_evt,
    input  logic          wake_en,
    input  logic          sleep_entry_evt,
    input  logic          por_flag_clr,
    input  logic          persist_we,
    input  logic [PW-1:0] persist_wdata,
    input  logic          sleep_en_set,
    input  logic          sleep_en_clr,
    output logic          sys_rst,
    output logic          cpu_rst,
    output logic          cold_rst,
    output logic          por_flag,
    output logic [PW-1:0] persist_q,
    output logic          sleep_en
);
    src_vec_t raw, en, qual;
    logic     req_any;

    always_comb begin
        raw.pin         = pin_evt;
        raw.wdog        = wdog_evt;
        raw.slpcnt      = slpcnt_evt;
        raw.wake        = wake_evt;
        raw.sleep_entry = sleep_entry_evt;
        en.pin          = pin_en;
        en.wdog         = wdog_en;
        en.slpcnt       = slpcnt_en;
        en.wake         = wake_en;
        en.sleep_entry  = 1'b1;
    end

    rst_gate u_gate (
        .raw     (raw),
        .en      (en),
        .mode    (op_mode_e'(op_mode)),
        .qual    (qual),
        .req_any (req_any)
    );

    rst_stretch #(.STRETCH(STRETCH)) u_stretch (
        .clk      (clk),
        .por      (pwr_on_rst),
        .req      (req_any),
        .sys_rst  (sys_rst),
        .cpu_rst  (cpu_rst),
        .cold_rst (cold_rst)
    );

    rst_persist #(.PW(PW)) u_persist (
        .clk      (clk),
        .por      (pwr_on_rst),
        .sys_rst  (sys_rst),
        .flag_clr (por_flag_clr),
        .we       (persist_we),
        .wdata    (persist_wdata),
        .slp_set  (sleep_en_set),
        .slp_clr  (sleep_en_clr),
        .por_flag (por_flag),
        .bits_q   (persist_q),
        .slp_en   (sleep_en)
    );
endmodule

// File: rtl/rst_hub_chk.sv
module rst_hub_chk #(
    parameter int PW = 8
) (
    input logic          clk,
    input logic          pwr_on_rst,
    input logic          req_any,
    input logic          sys_rst,
    input logic          cold_rst,
    input logic          por_flag,
    input logic          por_flag_clr,
    input logic [PW-1:0] persist_q,
    input logic          sleep_en
);
    AST_POR_STATE: assert property (@(posedge clk) disable iff (pwr_on_rst)
        $fell(pwr_on_rst) |-> (sys_rst && cold_rst && por_flag && persist_q == '0 && !sleep_en)); // R1

    AST_REQ_RESETS: assert property (@(posedge clk) disable iff (pwr_on_rst)
        req_any |=> sys_rst); // R2

    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (pwr_on_rst)
        (!sys_rst && !req_any) |=> !sys_rst); // R2

    AST_RESTART: assert property (@(posedge clk) disable iff (pwr_on_rst)
        $fell(sys_rst) |-> !$past(req_any)); // R11

    AST_COLD_ONLY_POR: assert property (@(posedge clk) disable iff (pwr_on_rst)
        (!cold_rst && !pwr_on_rst) |=> !cold_rst); // R4

    AST_HOLD_PERSIST: assert property (@(posedge clk) disable iff (pwr_on_rst)
        sys_rst |=> ($stable(persist_q) && $stable(sleep_en))); // R13

    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (pwr_on_rst)
        por_flag_clr |=> !por_flag); // R12
endmodule

bind rst_hub rst_hub_chk #(.PW(PW)) u_chk (
    .clk          (clk),
    .pwr_on_rst   (pwr_on_rst),
    .req_any      (req_any),
    .sys_rst      (sys_rst),
    .cold_rst     (cold_rst),
    .por_flag     (por_flag),
    .por_flag_clr (por_flag_clr),
    .persist_q    (persist_q),
    .sleep_en     (sleep_en)
);

// File: tb/sim_rst_hub.sv
`timescale 1ns/1ps
module sim_rst_hub;
    localparam int N  = 16;
    localparam int PW = 8;

    logic          clk = 1'b0;
    logic          pwr_on_rst = 1'b1;
    logic [1:0]    op_mode = 2'd0;
    logic          pin_evt = 0, pin_en = 0, wdog_evt = 0, wdog_en = 0;
    logic          slpcnt_evt = 0, slpcnt_en = 0, wake_evt = 0, wake_en = 0;
    logic          sleep_entry_evt = 0, por_flag_clr = 0, persist_we = 0;
    logic [PW-1:0] persist_wdata = '0;
    logic          sleep_en_set = 0, sleep_en_clr = 0;
    logic          sys_rst, cpu_rst, cold_rst, por_flag, sleep_en;
    logic [PW-1:0] persist_q;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    rst_hub #(.STRETCH(N), .PW(PW)) u0 (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected gating from R6..R10; src: 0 pin,1 wdog,2 slpcnt,3 wake,4 sleep entry
    function automatic bit exp_fire(input int src, input bit en, input int mode);
        case (src)
            0, 1:    return en && (mode == 0 || mode == 1);
            2:       return en && mode == 0;
            3:       return en && mode == 2;
            default: return 1'b1;
        endcase
    endfunction

    task automatic set_src(input int src, input bit v, input bit en);
        pin_en = 0; wdog_en = 0; slpcnt_en = 0; wake_en = 0;
        pin_evt = 0; wdog_evt = 0; slpcnt_evt = 0; wake_evt = 0; sleep_entry_evt = 0;
        case (src)
            0: begin pin_evt = v;    pin_en = en;    end
            1: begin wdog_evt = v;   wdog_en = en;   end
            2: begin slpcnt_evt = v; slpcnt_en = en; end
            3: begin wake_evt = v;   wake_en = en;   end
            default: sleep_entry_evt = v;
        endcase
    endtask

    // Raise at a negedge, lower at the next one; returns at that negedge.
    task automatic pulse(input int src, input bit en);
        set_src(src, 1'b1, en);
        @(negedge clk);
        set_src(src, 1'b0, en);
    endtask

    // Count negedges with sys_rst high, starting now; checks cpu_rst tracking (R3).
    task automatic measure(output int n, output bit cold_seen);
        n = 0; cold_seen = 0;
        while (sys_rst === 1'b1 && n < N + 8) begin
            chk("R3 cpu_rst", cpu_rst, sys_rst);
            if (cold_rst) cold_seen = 1;
            n++;
            @(negedge clk);
        end
    endtask

    task automatic write_persist(input logic [PW-1:0] v);
        persist_wdata = v; persist_we = 1;
        @(negedge clk);
        persist_we = 0;
    endtask

    initial begin
        #2_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n;
        bit cs;
        logic [PW-1:0] keep;
        logic keep_slp;
        void'($urandom(32'd1234));

        // R1: reset state, with a clear held during power-on (R12 set wins)
        por_flag_clr = 1;
        repeat (3) @(negedge clk);
        chk("R1 sys_rst", sys_rst, 1);
        chk("R1 cold_rst", cold_rst, 1);
        chk("R1 persist_q", persist_q, 0);
        chk("R1 sleep_en", sleep_en, 0);
        chk("R12 set beats clear", por_flag, 1);
        por_flag_clr = 0;
        pwr_on_rst = 0;
        measure(n, cs);
        chk("R2 POR stretch length", n, N);
        chk("R4 cold during POR stretch", cs, 1);
        chk("R4 cold released", cold_rst, 0);
        chk("R1 por_flag after release", por_flag, 1);

        // R12 clear
        por_flag_clr = 1; @(negedge clk); por_flag_clr = 0;
        chk("R12 flag cleared", por_flag, 0);

        // R13 writes and latch honoured outside reset
        write_persist(8'hA5);
        sleep_en_set = 1; @(negedge clk); sleep_en_set = 0;
        chk("R13 write outside reset", persist_q, 8'hA5);
        chk("R13 latch set outside reset", sleep_en, 1);

        // R11 restart: second request 4 cycles into the stretch
        pulse(4, 0);
        repeat (4) @(negedge clk);
        pulse(4, 0);
        measure(n, cs);
        chk("R11 restart length", n, N);

        // R13 writes ignored during reset; R5 state kept
        pulse(1, 1);
        write_persist(8'h3C);
        sleep_en_clr = 1; @(negedge clk); sleep_en_clr = 0;
        measure(n, cs);
        chk("R13 write ignored", persist_q, 8'hA5);
        chk("R13 latch clear ignored", sleep_en, 1);
        chk("R4 warm not cold", cs, 0);

        // Random sources, enables, modes: R5..R10
        for (int it = 0; it < 60; it++) begin
            int src, mode;
            bit en, fire;
            src  = int'($urandom_range(0, 4));
            mode = int'($urandom_range(0, 3));
            en   = 1'($urandom_range(0, 1));
            fire = exp_fire(src, en, mode);
            write_persist(PW'($urandom));
            keep = persist_q; keep_slp = sleep_en;
            op_mode = 2'(mode);
            pulse(src, en);
            if (fire) begin
                measure(n, cs);
                chk($sformatf("R%0s stretch src%0d mode%0d", src == 4 ? "10" : src == 3 ? "8" : src == 2 ? "9" : src == 1 ? "7" : "6", src, mode), n, N);
                chk("R4 warm reset keeps cold low", cs, 0);
                chk("R5 persist kept", persist_q, keep);
                chk("R5 sleep_en kept", sleep_en, keep_slp);
                chk("R5 por_flag kept", por_flag, 0);
            end else begin
                chk($sformatf("R6 R7 R8 R9 gated src%0d mode%0d en%0d", src, mode, en), sys_rst, 0);
                @(negedge clk);
                chk("R2 no reset without request", sys_rst, 0);
            end
            op_mode = 2'd0;
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule